// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block arbitrates among 256 interrupt vectors for one processor core. Requests arrive one vector per cycle and are latched in a request bitmap. The controller always offers the highest requested vector to the core, but only when that vector's priority class beats the current processor priority. When the core takes the offered vector, the controller moves it from the request bitmap into the in-service bitmap. It also pushes the vector onto a nesting stack. The processor priority is derived from the top of that stack and a software-written task priority.

An end-of-interrupt strobe retires the most important in-service vector and pops the stack. Vectors 0 to 31 are reserved. They may be latched, but they are never offered and never retired. Both bitmaps can be read at any time as 32-bit words through a combinational read port. A stack overflow or an end-of-interrupt with nothing in service raises a sticky error flag and changes nothing else.

The offered vector is a valid/ready stream towards the core: `pend_valid`/`pend_vec` is the offer and `take` is the ready. A transfer happens only in a cycle where `pend_valid` and `take` are both high, `eoi` is low and the stack is not full. `take` in any other cycle is ignored. The offer may change or drop between cycles without having been taken, because a new request or a task-priority write can raise the bar. The request port has no back-pressure and accepts a vector every cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Vector v is held at bitmap word v/32, bit v mod 32. `rd_sel`=0 reads the request bitmap, `rd_sel`=1 reads the in-service bitmap, and `rd_word` selects the word.
- R2: The processor priority `ppr` equals the task priority when the task priority class (bits 7:4) is at least the class of the top stack entry. Otherwise it is that top entry with bits 3:0 cleared. An empty stack counts as entry 0.
- R3: The controller searches only the highest set request among vectors 32 to 255. It offers that request only when its class is strictly greater than the class of `ppr`. Otherwise `pend_valid` is 0. Vectors 0 to 31 are never offered.
- R4: A transfer clears the request bit of the offered vector and sets its in-service bit. It also pushes the vector on the stack, so `ppr` follows from the next cycle.
- R5: Each `eoi` with a non-empty stack clears the highest set in-service bit in 32 to 255 and pops the stack, so `ppr` follows from the next cycle.
- R6: A `tpr_we` write keeps only `tpr_wdata[7:0]` as the task priority, and `ppr` reflects it from the next cycle.
- R7: A transfer attempted while the stack holds STK_DEPTH-1 vectors sets `err`. It leaves both bitmaps, the stack and the offer unchanged.
- R8: An `eoi` with an empty stack sets `err` and changes no other state.
- R9: A request arriving in the same cycle as a transfer of a different vector is kept. A request for the vector being transferred leaves that vector's request bit set.
- R10: After reset both bitmaps, the stack and the task priority are zero, so `ppr` is 0. `err` and `pend_valid` are 0.
- R11: `take` without `pend_valid`, or together with `eoi`, transfers nothing. In that case the `eoi` alone is performed.
- R12: `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Latch the request in `req_vec` this cycle |
| req_vec | input | 8 | Requested vector |
| pend_valid | output | 1 | A vector is offered to the core |
| pend_vec | output | 8 | Offered vector (0 when none) |
| take | input | 1 | Core is ready to take the offered vector |
| eoi | input | 1 | End of the current interrupt |
| tpr_we | input | 1 | Write task priority |
| tpr_wdata | input | 32 | Task priority write data (low 8 bits used) |
| ppr | output | 8 | Processor priority |
| err | output | 1 | Sticky overflow/underflow flag |
| rd_sel | input | 1 | 0 request bitmap, 1 in-service bitmap |
| rd_word | input | 3 | Bitmap word index |
| rd_data | output | 32 | Selected bitmap word |

## Verification
The bench builds the controller with the full 256 vectors and STK_DEPTH=4, so three nested vectors fill the stack. That makes the overflow path reachable with a short nesting chain across three classes. Each vector from 32 to 255 goes through a full request, transfer and retire cycle, with the bitmap word and `ppr` checked arithmetically. All 256 task priority values are swept against a fixed request. The 32 reserved vectors are latched to show that they are stored but never offered.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic {
    MAP_REQ = 1'b0,
    MAP_SVC = 1'b1
  } map_sel_e;
endpackage

// File: rtl/vic_bitmap.sv
module vic_bitmap #(
  parameter int NBITS = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NBITS-1:0] bits
);
  logic [NBITS-1:0] set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  // a set on the same index as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= (bits & ~clr_mask) | set_mask;
  end

  // R9
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits[$past(set_idx)]);

  // R1
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !bits[$past(clr_idx)]);
endmodule

// File: rtl/vic_hifind.sv
module vic_hifind #(
  parameter int NBITS = 256,
  parameter int LOW   = 32,
  parameter int IDX_W = 8
) (
  input  logic [NBITS-1:0] bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LOW; i < NBITS; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int CLS_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_val,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     ent [DEPTH];
  logic [PTR_W-1:0] ptr;

  assign top   = ent[ptr];
  assign empty = (ptr == '0);
  assign full  = (ptr == LAST);

  // entry 0 stays zero: the "nothing in service" placeholder
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (push && !full) begin
      ent[ptr + 1'b1] <= push_val;
      ptr             <= ptr + 1'b1;
    end else if (pop && !empty) begin
      ptr <= ptr - 1'b1;
    end
  end

  // R4
  push_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_val[W-1 -: CLS_W] > top[W-1 -: CLS_W]));

  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NVEC      = 256,
  parameter int RSVD      = 32,
  parameter int CLS_W     = 4,
  parameter int WORD_W    = 32,
  parameter int STK_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [$clog2(NVEC)-1:0]   req_vec,
  output logic                      pend_valid,
  output logic [$clog2(NVEC)-1:0]   pend_vec,
  input  logic                      take,
  input  logic                      eoi,
  input  logic                      tpr_we,
  input  logic [WORD_W-1:0]         tpr_wdata,
  output logic [$clog2(NVEC)-1:0]   ppr,
  output logic                      err,
  input  logic                      rd_sel,
  input  logic [$clog2(NVEC/WORD_W)-1:0] rd_word,
  output logic [WORD_W-1:0]         rd_data
);
  import vic_pkg::*;

  localparam int VEC_W = $clog2(NVEC);
  localparam int SUB_W = VEC_W - CLS_W;

  logic [NVEC-1:0]  req_bits, svc_bits;
  logic             req_hit, svc_hit;
  logic [VEC_W-1:0] req_hi, svc_hi;
  logic [VEC_W-1:0] stk_top, tpr_q;
  logic             stk_empty, stk_full;
  logic             acc_try, acc_fire, eoi_fire, err_q;
  logic [CLS_W-1:0] tpr_cls, top_cls, ppr_cls;
  logic             unused_tpr_hi;

  assign unused_tpr_hi = |tpr_wdata[WORD_W-1:VEC_W];

  // handshake decode
  assign acc_try  = take && pend_valid && !eoi;
  assign acc_fire = acc_try && !stk_full;
  assign eoi_fire = eoi && !stk_empty;

  vic_bitmap #(.NBITS(NVEC), .IDX_W(VEC_W)) u_req_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_valid), .set_idx(req_vec),
    .clr_en(acc_fire),  .clr_idx(pend_vec),
    .bits(req_bits));

  vic_bitmap #(.NBITS(NVEC), .IDX_W(VEC_W)) u_svc_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(acc_fire), .set_idx(pend_vec),
    .clr_en(eoi_fire), .clr_idx(svc_hi),
    .bits(svc_bits));

  vic_hifind #(.NBITS(NVEC), .LOW(RSVD), .IDX_W(VEC_W)) u_req_find (
    .bits(req_bits), .found(req_hit), .idx(req_hi));

  vic_hifind #(.NBITS(NVEC), .LOW(RSVD), .IDX_W(VEC_W)) u_svc_find (
    .bits(svc_bits), .found(svc_hit), .idx(svc_hi));

  vic_nest_stack #(.DEPTH(STK_DEPTH), .W(VEC_W), .CLS_W(CLS_W)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(acc_fire), .push_val(pend_vec),
    .pop(eoi_fire),
    .top(stk_top), .empty(stk_empty), .full(stk_full));

  // task priority and sticky error
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
      if ((acc_try && stk_full) || (eoi && stk_empty)) err_q <= 1'b1;
    end
  end
  assign err = err_q;

  // processor priority
  assign tpr_cls = tpr_q[VEC_W-1 -: CLS_W];
  assign top_cls = stk_top[VEC_W-1 -: CLS_W];
  assign ppr     = (tpr_cls >= top_cls) ? tpr_q : {top_cls, {SUB_W{1'b0}}};
  assign ppr_cls = ppr[VEC_W-1 -: CLS_W];

  // offer only the highest request, gated by its class
  assign pend_valid = req_hit && (req_hi[VEC_W-1 -: CLS_W] > ppr_cls);
  assign pend_vec   = pend_valid ? req_hi : '0;

  // bitmap read
  assign rd_data = (rd_sel == MAP_SVC) ? svc_bits[rd_word*WORD_W +: WORD_W]
                                       : req_bits[rd_word*WORD_W +: WORD_W];

  // R2
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr_cls >= tpr_cls) && (ppr_cls >= top_cls));

  // R3
  pend_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_vec >= VEC_W'(RSVD)) && (pend_vec[VEC_W-1 -: CLS_W] > ppr_cls));

  // R5
  eoi_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |-> (svc_hit && svc_hi == stk_top));

  // R7
  ovf_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_try && stk_full) |=> (err && svc_bits == $past(svc_bits)));

  // R8
  unf_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && stk_empty) |=> (err && svc_bits == $past(svc_bits)));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, take, eoi, tpr_we, rd_sel;
  logic [7:0]  req_vec;
  logic [31:0] tpr_wdata;
  logic [2:0]  rd_word;
  logic        pend_valid, err;
  logic [7:0]  pend_vec, ppr;
  logic [31:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.STK_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vec(req_vec),
    .pend_valid(pend_valid), .pend_vec(pend_vec),
    .take(take), .eoi(eoi),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .ppr(ppr), .err(err),
    .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    req_valid = 1'b0; take = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic rd(input bit sel, input int w, output logic [31:0] d);
    rd_sel = sel; rd_word = 3'(w);
    #1;
    d = rd_data;
  endtask

  task automatic req(input int v);
    req_valid = 1'b1; req_vec = 8'(v);
    tick();
  endtask

  task automatic wr_tpr(input logic [7:0] t);
    tpr_we = 1'b1; tpr_wdata = {24'hC3A5E1, t};
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    req_valid = 0; take = 0; eoi = 0; tpr_we = 0;
    req_vec = 0; tpr_wdata = 0; rd_sel = 0; rd_word = 0;
    #1;
    do_reset();

    // R10 reset state
    chk("R10 pend_valid", 32'(pend_valid), 0);
    chk("R10 ppr", 32'(ppr), 0);
    chk("R10 err", 32'(err), 0);
    for (int w = 0; w < 8; w++) begin
      rd(0, w, d); chk("R10 req word", d, 0);
      rd(1, w, d); chk("R10 svc word", d, 0);
    end

    // R3 reserved vectors are stored but never offered
    for (int v = 0; v < 32; v++) begin
      req(v);
      chk("R3 reserved not offered", 32'(pend_valid), 0);
    end
    rd(0, 0, d); chk("R1 reserved word0", d, 32'hFFFF_FFFF);
    rd(0, 1, d); chk("R1 word1 clear", d, 0);
    do_reset();

    // full sweep of deliverable vectors
    for (int v = 32; v < 256; v++) begin
      req(v);
      chk("R3 offer valid", 32'(pend_valid), 1);
      chk("R3 offer vec", 32'(pend_vec), v);
      rd(0, v / 32, d); chk("R1 req bit", d, 32'(1) << (v % 32));
      take = 1'b1; tick();
      chk("R4 ppr after take", 32'(ppr), v & 32'hF0);
      rd(1, v / 32, d); chk("R4 svc bit", d, 32'(1) << (v % 32));
      rd(0, v / 32, d); chk("R4 req cleared", d, 0);
      eoi = 1'b1; tick();
      chk("R5 ppr after eoi", 32'(ppr), 0);
      rd(1, v / 32, d); chk("R5 svc cleared", d, 0);
      chk("R5 no offer", 32'(pend_valid), 0);
    end
    chk("R8 no err in sweep", 32'(err), 0);

    // task priority sweep against request 0x85
    req(8'h85);
    for (int t = 0; t < 256; t++) begin
      wr_tpr(8'(t));
      chk("R6 ppr equals tpr", 32'(ppr), t);
      chk("R3 gate by tpr", 32'(pend_valid), ((t >> 4) < 8) ? 1 : 0);
    end
    do_reset();

    // R8 underflow
    eoi = 1'b1; tick();
    chk("R8 err on empty eoi", 32'(err), 1);
    chk("R8 ppr unchanged", 32'(ppr), 0);
    rd(1, 0, d); chk("R8 svc unchanged", d, 0);
    tick();
    chk("R12 err sticky", 32'(err), 1);
    do_reset();
    chk("R10 err cleared", 32'(err), 0);

    // nesting and overflow
    req(8'h40); take = 1'b1; tick();
    req(8'h45);
    chk("R3 same class blocked", 32'(pend_valid), 0);
    req(8'h90);
    chk("R3 highest offered", 32'(pend_vec), 32'h90);
    take = 1'b1; tick();
    chk("R2 ppr from stack", 32'(ppr), 32'h90);
    wr_tpr(8'h95);
    chk("R2 tpr class equal", 32'(ppr), 32'h95);
    wr_tpr(8'h85);
    chk("R2 stack class wins", 32'(ppr), 32'h90);
    wr_tpr(8'h00);
    req(8'hA0); take = 1'b1; tick();
    chk("R4 third nest", 32'(ppr), 32'hA0);
    req(8'hF0);
    chk("R3 offer F0", 32'(pend_vec), 32'hF0);
    chk("R7 no err yet", 32'(err), 0);
    take = 1'b1; tick();
    chk("R7 err on full", 32'(err), 1);
    chk("R7 ppr unchanged", 32'(ppr), 32'hA0);
    rd(1, 7, d); chk("R7 svc unchanged", d, 0);
    rd(0, 7, d); chk("R7 req kept", d, 32'h0001_0000);
    chk("R7 offer kept", 32'(pend_vec), 32'hF0);
    eoi = 1'b1; tick();
    chk("R5 pop to 90", 32'(ppr), 32'h90);
    rd(1, 5, d); chk("R5 A0 retired", d, 0);
    take = 1'b1; tick();
    chk("R4 F0 taken", 32'(ppr), 32'hF0);
    eoi = 1'b1; tick();
    chk("R5 pop F0", 32'(ppr), 32'h90);
    eoi = 1'b1; tick();
    chk("R5 pop 90", 32'(ppr), 32'h40);
    chk("R3 45 still blocked", 32'(pend_valid), 0);
    eoi = 1'b1; tick();
    chk("R5 pop 40", 32'(ppr), 0);
    chk("R3 45 offered", 32'(pend_vec), 32'h45);

    // R11 take together with eoi
    take = 1'b1; tick();
    chk("R4 45 taken", 32'(ppr), 32'h40);
    req(8'h70);
    take = 1'b1; eoi = 1'b1; tick();
    chk("R11 eoi performed", 32'(ppr), 0);
    rd(1, 3, d); chk("R11 70 not taken", d, 0);
    chk("R11 70 still offered", 32'(pend_vec), 32'h70);
    do_reset();

    // R11 take without offer
    take = 1'b1; tick();
    chk("R11 idle take", 32'(ppr), 0);
    rd(1, 1, d); chk("R11 idle svc", d, 0);

    // R9 request concurrent with transfer
    req(8'h60);
    req_valid = 1'b1; req_vec = 8'h50; take = 1'b1; tick();
    rd(1, 3, d); chk("R9 60 in service", d, 32'h1);
    rd(0, 2, d); chk("R9 50 kept", d, 32'h0001_0000);
    chk("R9 50 blocked", 32'(pend_valid), 0);
    eoi = 1'b1; tick();
    chk("R9 50 offered", 32'(pend_vec), 32'h50);
    req_valid = 1'b1; req_vec = 8'h50; take = 1'b1; tick();
    rd(1, 2, d); chk("R9 50 in service", d, 32'h0001_0000);
    rd(0, 2, d); chk("R9 same vector stays requested", d, 32'h0001_0000);

    finish_run();
  end
endmodule